// File: doc/BRIEF.md
# Interrupt and Exception Event Arbiter

This block sits beside an instruction pipeline and, at each instruction boundary, picks the one pending event that the core takes. It returns the 8-bit vector for that event and a class tag that tells the core whether the saved return point is the faulting instruction or the one after it. Candidate events are:

- a hardware reset request and a machine check;
- a task-switch trap and an external hardware intervention;
- a trap raised by the instruction that just completed;
- a non-maskable interrupt, detected on its rising edge;
- a level-sensitive maskable request;
- a code breakpoint fault, and fetch, decode and execute faults.

A latched trap or intervention that loses arbitration stays pending and competes again at the next boundary. A fault that loses is dropped, because re-execution raises it again. The block holds a non-maskable-interrupt guard from the moment that interrupt is taken until the core signals that its handler has returned. During that time one further edge is remembered.

After a stack-segment load, the block opens a short window in which it will not take maskable interrupts, breakpoint faults or single-step traps. This keeps the stack pointer update atomic with the segment load. A reset request overrides everything in the cycle it is seen and wipes all pending state.

Top module: `intr_event_arbiter`

## Requirements
- R1: While `reset_req` is high, `take` is 1, `take_class` is 5 and `take_vec` is 0 in that same cycle, with or without `boundary`. The request also clears every latched event, a pending non-maskable edge and the non-maskable guard.
- R2: Apart from R1, `take` rises only in a cycle with `boundary` high, and at most one event is taken per boundary. With nothing taken, `take_vec` is 0 and `take_class` is 0.
- R3: The ranking, from highest to lowest, is:
  - machine check
  - task-switch trap
  - external intervention
  - previous-instruction trap
  - non-maskable interrupt
  - maskable request
  - breakpoint fault
  - fetch fault
  - decode fault
  - execute fault
- R4: A maskable request is taken only while `if_flag` is 1. While `if_flag` is 0 the request stays pending for as long as the input is held, and it is taken at the first boundary after `if_flag` becomes 1.
- R5: `if_flag` has no effect on non-maskable interrupts or on any exception source.
- R6: A rising edge on `nmi_pin` is taken with vector 2 and class 3.
- R7: From the cycle after a non-maskable interrupt is taken until `nmi_return`, neither another non-maskable interrupt nor a maskable request is taken. Exceptions are still taken during that time.
- R8: Any number of `nmi_pin` edges seen while the guard is up leave exactly one pending interrupt. That interrupt is taken at the first boundary at or after `nmi_return`.
- R9: If `ss_load` is high in a cycle, the next boundary (or the same cycle, if `boundary` is also high) takes no maskable request, breakpoint fault or previous-instruction trap. The boundary after that is unaffected. Non-maskable interrupts and other faults are not inhibited.
- R10: The class codes in `take_class` are:
  - fault = 1
  - trap = 2
  - interrupt = 3
  - abort = 4
  - reset = 5
  - intervention = 6

  A machine check is taken with vector 18 and class 4. A task-switch or previous-instruction trap uses class 2, and every fault source uses class 1.
- R11: A latched event that loses arbitration is taken at a later boundary. A fault that loses, or that sees no boundary, is not remembered.
- R12: The machine-check, task-switch, intervention and previous-instruction pulses, and `nmi_pin` edges, are latched at the clock edge. They become eligible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| reset_req | input | 1 | Hardware reset event; overriding |
| mcheck_req | input | 1 | Machine-check pulse |
| tsw_trap_req | input | 1 | Task-switch trap pulse |
| tsw_trap_vec | input | 8 | Vector for the task-switch trap |
| intv_req | input | 1 | External intervention pulse |
| intv_vec | input | 8 | Vector for the intervention |
| prev_trap_req | input | 1 | Trap pulse from the completed instruction |
| prev_trap_vec | input | 8 | Vector for that trap |
| nmi_pin | input | 1 | Non-maskable request, edge-detected |
| intr_req | input | 1 | Maskable request, level |
| intr_vec | input | 8 | Vector of the maskable request |
| bkpt_fault | input | 1 | Code breakpoint fault, sampled at boundary |
| bkpt_vec | input | 8 | Vector of the breakpoint fault |
| fetch_fault | input | 1 | Fetch fault, sampled at boundary |
| fetch_vec | input | 8 | Vector of the fetch fault |
| decode_fault | input | 1 | Decode fault, sampled at boundary |
| decode_vec | input | 8 | Vector of the decode fault |
| exec_fault | input | 1 | Execute fault, sampled at boundary |
| exec_vec | input | 8 | Vector of the execute fault |
| if_flag | input | 1 | Interrupt-enable flag |
| boundary | input | 1 | Instruction boundary strobe |
| ss_load | input | 1 | Stack-segment load strobe |
| nmi_return | input | 1 | Non-maskable handler return strobe |
| take | output | 1 | An event is taken this cycle |
| take_vec | output | 8 | Vector of the taken event |
| take_class | output | 3 | Class code of the taken event |

## Verification
The bench builds the block with `SHADOW_LEN` at 1, its default. At that value the inhibit window after a stack-segment load spans exactly one boundary, so the bench can watch a held maskable request being refused at one boundary and taken at the next.

The package fixes vectors at 8 bits. This lets the stimulus mix reserved exception vectors below 32 with device vectors above 32, so every source carries a distinct vector and a wrong winner shows up directly in `take_vec`.

// File: rtl/intr_arb_pkg.sv
package intr_arb_pkg;

    localparam int VEC_W = 8;
    typedef logic [VEC_W-1:0] vec_t;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_FAULT = 3'd1,
        CLS_TRAP  = 3'd2,
        CLS_INTR  = 3'd3,
        CLS_ABORT = 3'd4,
        CLS_RESET = 3'd5,
        CLS_INTV  = 3'd6
    } evt_cls_e;

    typedef struct packed {
        logic     req;
        vec_t     vec;
        evt_cls_e cls;
    } cand_t;

    localparam vec_t NMI_VEC  = VEC_W'(2);
    localparam vec_t MCHK_VEC = VEC_W'(18);
    localparam vec_t RST_VEC  = '0;

    // rank positions, 0 is strongest
    localparam int IDX_MC    = 0;
    localparam int IDX_TSW   = 1;
    localparam int IDX_INTV  = 2;
    localparam int IDX_PREV  = 3;
    localparam int IDX_NMI   = 4;
    localparam int IDX_MASK  = 5;
    localparam int IDX_BKPT  = 6;
    localparam int IDX_FETCH = 7;
    localparam int IDX_DEC   = 8;
    localparam int IDX_EXEC  = 9;
    localparam int N_RANK    = 10;
    localparam int N_HOLD    = 4;

    function automatic cand_t mk_cand(logic r, vec_t v, evt_cls_e c);
        cand_t x;
        x.req = r;
        x.vec = v;
        x.cls = c;
        return x;
    endfunction

endpackage

// File: rtl/evt_hold.sv
module evt_hold
    import intr_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic set_i,
    input  vec_t vec_i,
    input  logic take_i,
    output logic pend_o,
    output vec_t vec_o
);
    logic pend_q;
    vec_t vec_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pend_q <= 1'b0;
            vec_q  <= '0;
        end else begin
            pend_q <= set_i | (pend_q & ~take_i);
            if (set_i)
                vec_q <= vec_i;
        end
    end

    assign pend_o = pend_q;
    assign vec_o  = vec_q;
endmodule

// File: rtl/nmi_gate.sv
module nmi_gate (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic pin_i,
    input  logic taken_i,
    input  logic return_i,
    output logic pend_o,
    output logic blk_q_o,
    output logic blk_eff_o
);
    logic pin_q;
    logic pend_q;
    logic blk_q;
    logic edge_seen;

    assign edge_seen = pin_i & ~pin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q  <= 1'b0;
            pend_q <= 1'b0;
            blk_q  <= 1'b0;
        end else begin
            pin_q <= pin_i;
            if (clr_i) begin
                pend_q <= 1'b0;
                blk_q  <= 1'b0;
            end else begin
                pend_q <= taken_i ? edge_seen : (pend_q | edge_seen);
                blk_q  <= taken_i | (blk_q & ~return_i);
            end
        end
    end

    assign pend_o    = pend_q;
    assign blk_q_o   = blk_q;
    assign blk_eff_o = blk_q & ~return_i;
endmodule

// File: rtl/shadow_ctr.sv
module shadow_ctr #(
    parameter int LEN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic load_i,
    input  logic boundary_i,
    output logic shadow_o
);
    localparam int CW = (LEN < 1) ? 1 : $clog2(LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(LEN);
    localparam logic [CW-1:0] REST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (boundary_i) begin
            if (load_i)
                cnt_q <= REST;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - CW'(1);
        end else if (load_i) begin
            cnt_q <= FULL;
        end
    end

    assign shadow_o = (cnt_q != '0) | load_i;
endmodule

// File: rtl/rank_pick.sv
module rank_pick
    import intr_arb_pkg::*;
#(
    parameter int N = N_RANK
) (
    input  cand_t [N-1:0] cand_i,
    output logic  [N-1:0] win_o,
    output cand_t         sel_o
);
    always_comb begin
        logic found;
        found = 1'b0;
        win_o = '0;
        sel_o = mk_cand(1'b0, '0, CLS_NONE);
        for (int i = 0; i < N; i++) begin
            if (cand_i[i].req && !found) begin
                found    = 1'b1;
                win_o[i] = 1'b1;
                sel_o    = cand_i[i];
            end
        end
    end
endmodule

// File: rtl/intr_event_arbiter.sv
module intr_event_arbiter
    import intr_arb_pkg::*;
#(
    parameter int SHADOW_LEN = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reset_req,
    input  logic             mcheck_req,
    input  logic             tsw_trap_req,
    input  logic [VEC_W-1:0] tsw_trap_vec,
    input  logic             intv_req,
    input  logic [VEC_W-1:0] intv_vec,
    input  logic             prev_trap_req,
    input  logic [VEC_W-1:0] prev_trap_vec,
    input  logic             nmi_pin,
    input  logic             intr_req,
    input  logic [VEC_W-1:0] intr_vec,
    input  logic             bkpt_fault,
    input  logic [VEC_W-1:0] bkpt_vec,
    input  logic             fetch_fault,
    input  logic [VEC_W-1:0] fetch_vec,
    input  logic             decode_fault,
    input  logic [VEC_W-1:0] decode_vec,
    input  logic             exec_fault,
    input  logic [VEC_W-1:0] exec_vec,
    input  logic             if_flag,
    input  logic             boundary,
    input  logic             ss_load,
    input  logic             nmi_return,
    output logic             take,
    output logic [VEC_W-1:0] take_vec,
    output logic [2:0]       take_class
);
    logic [N_HOLD-1:0] h_set, h_pend, h_take;
    vec_t              h_vin  [N_HOLD];
    vec_t              h_vout [N_HOLD];

    cand_t [N_RANK-1:0] cands;
    logic  [N_RANK-1:0] win;
    cand_t              sel;

    logic nmi_pend, nmi_blk, nmi_blk_eff, nmi_taken;
    logic shadow_on;
    logic commit;

    assign commit = boundary & ~reset_req;

    assign h_set = {prev_trap_req, intv_req, tsw_trap_req, mcheck_req};
    assign h_vin[IDX_MC]   = MCHK_VEC;
    assign h_vin[IDX_TSW]  = tsw_trap_vec;
    assign h_vin[IDX_INTV] = intv_vec;
    assign h_vin[IDX_PREV] = prev_trap_vec;
    assign h_take = win[N_HOLD-1:0] & {N_HOLD{commit}};

    genvar g;
    generate
        for (g = 0; g < N_HOLD; g++) begin : g_hold
            evt_hold u_hold (
                .clk    (clk),
                .rst    (rst),
                .clr_i  (reset_req),
                .set_i  (h_set[g]),
                .vec_i  (h_vin[g]),
                .take_i (h_take[g]),
                .pend_o (h_pend[g]),
                .vec_o  (h_vout[g])
            );
        end
    endgenerate

    assign nmi_taken = commit & win[IDX_NMI];

    nmi_gate u_nmi (
        .clk       (clk),
        .rst       (rst),
        .clr_i     (reset_req),
        .pin_i     (nmi_pin),
        .taken_i   (nmi_taken),
        .return_i  (nmi_return),
        .pend_o    (nmi_pend),
        .blk_q_o   (nmi_blk),
        .blk_eff_o (nmi_blk_eff)
    );

    shadow_ctr #(.LEN(SHADOW_LEN)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (reset_req),
        .load_i     (ss_load),
        .boundary_i (boundary),
        .shadow_o   (shadow_on)
    );

    always_comb begin
        cands[IDX_MC]    = mk_cand(h_pend[IDX_MC], h_vout[IDX_MC], CLS_ABORT);
        cands[IDX_TSW]   = mk_cand(h_pend[IDX_TSW], h_vout[IDX_TSW], CLS_TRAP);
        cands[IDX_INTV]  = mk_cand(h_pend[IDX_INTV], h_vout[IDX_INTV], CLS_INTV);
        cands[IDX_PREV]  = mk_cand(h_pend[IDX_PREV] & ~shadow_on, h_vout[IDX_PREV], CLS_TRAP);
        cands[IDX_NMI]   = mk_cand(nmi_pend & ~nmi_blk_eff, NMI_VEC, CLS_INTR);
        cands[IDX_MASK]  = mk_cand(intr_req & if_flag & ~nmi_blk_eff & ~shadow_on,
                                   intr_vec, CLS_INTR);
        cands[IDX_BKPT]  = mk_cand(bkpt_fault & ~shadow_on, bkpt_vec, CLS_FAULT);
        cands[IDX_FETCH] = mk_cand(fetch_fault, fetch_vec, CLS_FAULT);
        cands[IDX_DEC]   = mk_cand(decode_fault, decode_vec, CLS_FAULT);
        cands[IDX_EXEC]  = mk_cand(exec_fault, exec_vec, CLS_FAULT);
    end

    rank_pick #(.N(N_RANK)) u_pick (
        .cand_i (cands),
        .win_o  (win),
        .sel_o  (sel)
    );

    always_comb begin
        if (reset_req) begin
            take       = 1'b1;
            take_vec   = RST_VEC;
            take_class = CLS_RESET;
        end else if (boundary && sel.req) begin
            take       = 1'b1;
            take_vec   = sel.vec;
            take_class = sel.cls;
        end else begin
            take       = 1'b0;
            take_vec   = '0;
            take_class = CLS_NONE;
        end
    end
endmodule

// File: rtl/intr_arb_checker.sv
module intr_arb_checker
    import intr_arb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reset_req,
    input logic              boundary,
    input logic              if_flag,
    input logic              nmi_return,
    input logic              take,
    input logic [VEC_W-1:0]  take_vec,
    input logic [2:0]        take_class,
    input logic [N_RANK-1:0] win,
    input logic              shadow_on,
    input logic              nmi_blk
);
    assert_reset_override_R1: assert property (@(posedge clk) disable iff (rst)
        reset_req |-> (take && take_class == CLS_RESET && take_vec == RST_VEC));

    assert_reset_unblocks_R1: assert property (@(posedge clk) disable iff (rst)
        reset_req |=> !nmi_blk);

    assert_take_at_boundary_R2: assert property (@(posedge clk) disable iff (rst)
        take |-> (boundary || reset_req));

    assert_single_winner_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win));

    assert_masked_only_nmi_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !reset_req && take_class == CLS_INTR && !if_flag) |-> (take_vec == NMI_VEC));

    assert_guard_blocks_intr_R7: assert property (@(posedge clk) disable iff (rst)
        (boundary && nmi_blk && !nmi_return && !reset_req) |-> !(take && take_class == CLS_INTR));

    assert_shadow_inhibit_R9: assert property (@(posedge clk) disable iff (rst)
        shadow_on |-> (!win[IDX_MASK] && !win[IDX_BKPT] && !win[IDX_PREV]));
endmodule

bind intr_event_arbiter intr_arb_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .reset_req  (reset_req),
    .boundary   (boundary),
    .if_flag    (if_flag),
    .nmi_return (nmi_return),
    .take       (take),
    .take_vec   (take_vec),
    .take_class (take_class),
    .win        (win),
    .shadow_on  (shadow_on),
    .nmi_blk    (nmi_blk)
);

// File: tb/intr_event_arbiter_bench.sv
`timescale 1ns/1ps
module intr_event_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       reset_req, mcheck_req, tsw_trap_req, intv_req, prev_trap_req;
    logic       nmi_pin, intr_req, bkpt_fault, fetch_fault, decode_fault, exec_fault;
    logic       if_flag, boundary, ss_load, nmi_return;
    logic [7:0] tsw_trap_vec, intv_vec, prev_trap_vec, intr_vec;
    logic [7:0] bkpt_vec, fetch_vec, decode_vec, exec_vec;
    logic       take;
    logic [7:0] take_vec;
    logic [2:0] take_class;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    intr_event_arbiter u_intr_event_arbiter (
        .clk(clk), .rst(rst), .reset_req(reset_req),
        .mcheck_req(mcheck_req),
        .tsw_trap_req(tsw_trap_req), .tsw_trap_vec(tsw_trap_vec),
        .intv_req(intv_req), .intv_vec(intv_vec),
        .prev_trap_req(prev_trap_req), .prev_trap_vec(prev_trap_vec),
        .nmi_pin(nmi_pin),
        .intr_req(intr_req), .intr_vec(intr_vec),
        .bkpt_fault(bkpt_fault), .bkpt_vec(bkpt_vec),
        .fetch_fault(fetch_fault), .fetch_vec(fetch_vec),
        .decode_fault(decode_fault), .decode_vec(decode_vec),
        .exec_fault(exec_fault), .exec_vec(exec_vec),
        .if_flag(if_flag), .boundary(boundary), .ss_load(ss_load),
        .nmi_return(nmi_return),
        .take(take), .take_vec(take_vec), .take_class(take_class)
    );

    // pul = {mc, tsw, intv, prev, nmi}; lvl = {intr, if, bkpt, fetch, dec, exec, ss}
    typedef struct packed {
        logic [4:0] pul;
        logic [6:0] lvl;
        logic       tk;
        logic [7:0] v;
        logic [2:0] c;
    } row_t;

    localparam int NROWS = 18;
    localparam row_t ROWS [NROWS] = '{
        {5'b00000, 7'b0100010, 1'b1, 8'h0D, 3'd1},  // execute only
        {5'b00000, 7'b0000110, 1'b1, 8'h06, 3'd1},  // decode over execute
        {5'b00000, 7'b0001110, 1'b1, 8'h0E, 3'd1},  // fetch over decode
        {5'b00000, 7'b0011000, 1'b1, 8'h11, 3'd1},  // breakpoint over fetch
        {5'b00000, 7'b1110000, 1'b1, 8'h41, 3'd3},  // maskable over breakpoint
        {5'b00000, 7'b1010000, 1'b1, 8'h11, 3'd1},  // R4: IF clear, breakpoint wins
        {5'b00000, 7'b1000000, 1'b0, 8'h00, 3'd0},  // R4: IF clear, nothing
        {5'b00001, 7'b1100000, 1'b1, 8'h02, 3'd3},  // NMI over maskable
        {5'b00001, 7'b0000000, 1'b1, 8'h02, 3'd3},  // R5: NMI with IF clear
        {5'b00011, 7'b0000000, 1'b1, 8'h03, 3'd2},  // prev trap over NMI
        {5'b00110, 7'b0000000, 1'b1, 8'h50, 3'd6},  // intervention over prev trap
        {5'b01100, 7'b0000000, 1'b1, 8'h01, 3'd2},  // task switch over intervention
        {5'b11000, 7'b0000000, 1'b1, 8'h12, 3'd4},  // machine check over task switch
        {5'b00000, 7'b0000010, 1'b1, 8'h0D, 3'd1},  // R5: fault with IF clear
        {5'b00000, 7'b1100011, 1'b1, 8'h0D, 3'd1},  // R9: shadow hides maskable
        {5'b00010, 7'b0001001, 1'b1, 8'h0E, 3'd1},  // R9: shadow hides prev trap
        {5'b00001, 7'b1100001, 1'b1, 8'h02, 3'd3},  // R9: NMI not shadowed
        {5'b00000, 7'b0000000, 1'b0, 8'h00, 3'd0}   // idle boundary
    };

    task automatic chk(input string tag, input logic et, input logic [7:0] ev,
                       input logic [2:0] ec);
        checks++;
        if (take !== et || take_vec !== ev || take_class !== ec) begin
            errors++;
            $display("FAIL %s: got take=%0b vec=%02h cls=%0d, expected take=%0b vec=%02h cls=%0d",
                     tag, take, take_vec, take_class, et, ev, ec);
        end
    endtask

    task automatic step();
        @(negedge clk);
        reset_req = 0; mcheck_req = 0; tsw_trap_req = 0; intv_req = 0;
        prev_trap_req = 0; bkpt_fault = 0; fetch_fault = 0; decode_fault = 0;
        exec_fault = 0; boundary = 0; ss_load = 0; nmi_return = 0;
    endtask

    task automatic clear_evt();
        step(); reset_req = 1;
        step();
    endtask

    task automatic nmi_edge();
        nmi_pin = 1;
        step();
        nmi_pin = 0;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; nmi_pin = 0; intr_req = 0; if_flag = 0;
        tsw_trap_vec = 8'h01; intv_vec = 8'h50; prev_trap_vec = 8'h03; intr_vec = 8'h41;
        bkpt_vec = 8'h11; fetch_vec = 8'h0E; decode_vec = 8'h06; exec_vec = 8'h0D;
        step(); step(); step();
        rst = 0;
        step(); #1 chk("R2 idle after block reset", 0, 8'h00, 3'd0);

        // table walk: R3/R10 ranking and classes
        for (int i = 0; i < NROWS; i++) begin
            clear_evt();
            {mcheck_req, tsw_trap_req, intv_req, prev_trap_req, nmi_pin} = ROWS[i].pul;
            step();
            nmi_pin = 0;
            {intr_req, if_flag, bkpt_fault, fetch_fault, decode_fault, exec_fault, ss_load} = ROWS[i].lvl;
            boundary = 1;
            #1 chk($sformatf("R3/R10 table row %0d", i), ROWS[i].tk, ROWS[i].v, ROWS[i].c);
            step(); intr_req = 0; if_flag = 0;
        end

        // R1: override without boundary, then pending state gone
        clear_evt();
        mcheck_req = 1;
        step(); reset_req = 1;
        #1 chk("R1 reset override", 1, 8'h00, 3'd5);
        step(); boundary = 1;
        #1 chk("R1 machine check cleared", 0, 8'h00, 3'd0);
        step(); nmi_edge(); boundary = 1;
        #1 chk("R6 NMI vector", 1, 8'h02, 3'd3);
        step(); reset_req = 1;
        step(); nmi_edge(); boundary = 1;
        #1 chk("R1 NMI guard cleared", 1, 8'h02, 3'd3);

        // R2: no take without boundary; latched event held
        clear_evt();
        exec_fault = 1;
        #1 chk("R2 fault without boundary", 0, 8'h00, 3'd0);
        step(); mcheck_req = 1;
        step(); step();
        #1 chk("R2 pending without boundary", 0, 8'h00, 3'd0);
        step(); boundary = 1;
        #1 chk("R11 machine check held", 1, 8'h12, 3'd4);

        // R7/R8: guard and single remembered edge
        clear_evt();
        nmi_edge(); boundary = 1;
        #1 chk("R6 first NMI", 1, 8'h02, 3'd3);
        step(); nmi_edge(); nmi_edge();
        intr_req = 1; if_flag = 1; boundary = 1;
        #1 chk("R7 NMI and maskable blocked", 0, 8'h00, 3'd0);
        step(); exec_fault = 1; boundary = 1;
        #1 chk("R7 fault passes guard", 1, 8'h0D, 3'd1);
        step(); nmi_return = 1;
        #1 chk("R8 return without boundary", 0, 8'h00, 3'd0);
        step(); boundary = 1;
        #1 chk("R8 remembered NMI", 1, 8'h02, 3'd3);
        step(); nmi_return = 1;
        step(); boundary = 1;
        #1 chk("R8 only one remembered", 1, 8'h41, 3'd3);
        step(); intr_req = 0; if_flag = 0;

        // R9: shadow across two boundaries
        clear_evt();
        ss_load = 1; intr_req = 1; if_flag = 1;
        step(); boundary = 1;
        #1 chk("R9 shadowed boundary", 0, 8'h00, 3'd0);
        step(); boundary = 1;
        #1 chk("R9 following boundary", 1, 8'h41, 3'd3);
        step(); intr_req = 0; if_flag = 0;

        // R11: losers
        clear_evt();
        mcheck_req = 1; prev_trap_req = 1;
        step(); boundary = 1;
        #1 chk("R11 machine check first", 1, 8'h12, 3'd4);
        step(); boundary = 1;
        #1 chk("R11 trap kept", 1, 8'h03, 3'd2);
        clear_evt();
        mcheck_req = 1;
        step(); boundary = 1; exec_fault = 1;
        #1 chk("R11 fault loses", 1, 8'h12, 3'd4);
        step(); boundary = 1;
        #1 chk("R11 fault not kept", 0, 8'h00, 3'd0);

        // R12: pulse eligible from next cycle
        clear_evt();
        tsw_trap_req = 1; boundary = 1;
        #1 chk("R12 same cycle", 0, 8'h00, 3'd0);
        step(); boundary = 1;
        #1 chk("R12 next cycle", 1, 8'h01, 3'd2);

        // R4: pending while IF clear
        clear_evt();
        intr_req = 1; if_flag = 0; boundary = 1;
        #1 chk("R4 IF clear", 0, 8'h00, 3'd0);
        step(); if_flag = 1; boundary = 1;
        #1 chk("R4 IF set", 1, 8'h41, 3'd3);
        step(); intr_req = 0; if_flag = 0;

        // R5: exception with IF clear
        clear_evt();
        decode_fault = 1; boundary = 1;
        #1 chk("R5 decode fault, IF clear", 1, 8'h06, 3'd1);
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule